// File: doc/BRIEF.md
# Two-Wire Acknowledge-Polling Sequencer

A serial EEPROM runs a self-timed internal write cycle after the Stop condition that closes a write. While that cycle runs, the target does not acknowledge its own address. This block runs on the host side and finds the end of that cycle by polling, rather than waiting out a fixed worst-case delay. Each probe is a Start condition followed by the device address byte with the direction bit at 0 (write). A NACK means the target is still busy. The sequencer then closes the bus with a Stop, waits a programmable gap and probes again. The first ACK marks the end of the write cycle.

The block issues commands to a byte-level two-wire engine. On `req_o` it presents one command and holds it until the engine pulses `done_i`. For a byte transfer the engine also returns the target's acknowledge on `ack_i`. When a probe is acknowledged, `hold_bus_i` selects what happens next. One choice leaves the bus open so the next transaction can follow without a Stop. The other closes the bus with a Stop. A probe limit ends a poll that never succeeds with a timeout flag. A count of the probes sent is available on a port.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `busy_o`, `ready_o`, `timeout_o` and `req_o` are 0 and `probe_cnt_o` is 0.
- R2: Every probe is a Start command (`cmd_o`=0) followed by a byte command (`cmd_o`=1) whose `data_o` is `{dev_addr, 1'b0}`, with bit 0 the direction bit. `dev_addr` is the value of `dev_addr_i` captured when polling began.
- R3: When a byte command completes with `ack_i`=0 and it was not the last allowed probe, a Stop command (`cmd_o`=2) follows at once. After the Stop completes, `req_o` stays low for exactly `gap_i`+1 cycles, and then the next Start is requested.
- R4: When a probe is acknowledged and `hold_bus_i`=0, a Stop command follows at once. In the cycle after that Stop completes, `ready_o`=1 and `busy_o`=0.
- R5: When a probe is acknowledged and `hold_bus_i`=1, no Stop is issued. In the cycle after the byte completes, `ready_o`=1, `busy_o`=0 and `req_o`=0.
- R6: At the end of polling, `probe_cnt_o` equals the number of address bytes sent, including the acknowledged one.
- R7: If probe number `max_probes_i` is NACKed, the sequencer issues a Stop and then stops with `timeout_o`=1 and `ready_o`=0, and it issues no further commands. A `max_probes_i` of 0 acts as 1.
- R8: A `start_i` pulse while `busy_o`=1 is ignored. The command sequence and the probe count continue undisturbed.
- R9: A `start_i` pulse while idle clears `ready_o`, `timeout_o` and `probe_cnt_o`, and `req_o` rises with a Start command in the next cycle.
- R10: While `req_o`=1 and `done_i`=0, `req_o`, `cmd_o` and `data_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (pulse, honoured only when idle) |
| dev_addr_i | input | 7 | Target device address |
| max_probes_i | input | 8 | Probe limit before timeout (0 treated as 1) |
| gap_i | input | 8 | Idle cycles between probes, minus one |
| hold_bus_i | input | 1 | 1: leave the bus open after the ACK; 0: send a Stop |
| req_o | output | 1 | Command request to the byte engine |
| cmd_o | output | 2 | Command: 0 Start, 1 send byte, 2 Stop |
| data_o | output | 8 | Byte to send for command 1 |
| done_i | input | 1 | Engine completed the current command (pulse) |
| ack_i | input | 1 | Acknowledge sampled for a byte command, valid with done_i |
| busy_o | output | 1 | Polling in progress |
| ready_o | output | 1 | Target acknowledged; next operation may start |
| timeout_o | output | 1 | Probe limit reached without an ACK |
| probe_cnt_o | output | 8 | Number of probes sent in this poll |

## Verification
Some properties are checked on every cycle. A pending request keeps its command and byte stable. A byte command always carries a 0 direction bit. A Start is entered only from idle or from the inter-probe gap. The gap counter steps down by one each cycle. The probe counter never wraps, and the ready and timeout flags are never set together.

Other behaviour appears only in the bench's scenarios, because the expected value depends on how many NACKs the target returns. This covers the exact gap length and the count of probes at the end. It also covers which choice of `hold_bus_i` leads to a Stop and which does not, when the timeout fires, and the fact that a start pulse sent during a poll does not restart it.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_STOP_NAK,
    ST_GAP,
    ST_STOP_OK,
    ST_STOP_TO
  } poll_state_e;
endpackage

// File: rtl/ap_gap_timer.sv
module ap_gap_timer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             expired_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= gap_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ap_probe_counter.sv
module ap_probe_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the probe in flight is the last one if its ordinal reaches the limit
  assign next_ext = {1'b0, cnt_q} + 1'b1;
  assign last_o   = (next_ext >= {1'b0, max_i});
  assign cnt_o    = cnt_q;

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q != '1));
endmodule

// File: rtl/ap_seq_fsm.sv
module ap_seq_fsm
  import ack_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              hold_bus_i,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic              last_i,
  input  logic              gap_expired_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              gap_load_o,
  output logic              req_o,
  output logic [1:0]        cmd_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              timeout_o
);
  poll_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              ready_q, tmo_q;
  logic              accept;
  bus_cmd_e          cmd;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_START;
      ST_START:    if (done_i)  state_d = ST_ADDR;
      ST_ADDR:
        if (done_i) begin
          if (ack_i)       state_d = hold_bus_i ? ST_IDLE : ST_STOP_OK;
          else if (last_i) state_d = ST_STOP_TO;
          else             state_d = ST_STOP_NAK;
        end
      ST_STOP_NAK: if (done_i)        state_d = ST_GAP;
      ST_GAP:      if (gap_expired_i) state_d = ST_START;
      ST_STOP_OK:  if (done_i)        state_d = ST_IDLE;
      ST_STOP_TO:  if (done_i)        state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ready_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= dev_addr_i;
        ready_q <= 1'b0;
        tmo_q   <= 1'b0;
      end else if (done_i) begin
        if ((state_q == ST_ADDR && ack_i && hold_bus_i) || state_q == ST_STOP_OK)
          ready_q <= 1'b1;
        if (state_q == ST_STOP_TO)
          tmo_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: cmd = CMD_START;
      ST_ADDR:  cmd = CMD_BYTE;
      default:  cmd = CMD_STOP;
    endcase
  end

  assign req_o      = (state_q != ST_IDLE) && (state_q != ST_GAP);
  assign cmd_o      = cmd;
  assign data_o     = {addr_q, 1'b0};
  assign busy_o     = (state_q != ST_IDLE);
  assign ready_o    = ready_q;
  assign timeout_o  = tmo_q;
  assign cnt_clr_o  = accept;
  assign cnt_inc_o  = (state_q == ST_ADDR) && done_i;
  assign gap_load_o = (state_q == ST_STOP_NAK) && done_i;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> (req_o && $stable(cmd_o) && $stable(data_o)));

  p_rw_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cmd_o == CMD_BYTE) |-> (data_o[0] == 1'b0));

  p_start_origin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) != ST_START)
      |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_GAP));

  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && timeout_o));

  p_ready_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !busy_o);
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned GAP_W  = 8,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [CNT_W-1:0]  max_probes_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              hold_bus_i,
  output logic              req_o,
  output logic [1:0]        cmd_o,
  output logic [BYTE_W-1:0] data_o,
  input  logic              done_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  probe_cnt_o
);
  logic cnt_clr, cnt_inc, last, gap_load, gap_expired;

  ap_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .dev_addr_i    (dev_addr_i),
    .hold_bus_i    (hold_bus_i),
    .done_i        (done_i),
    .ack_i         (ack_i),
    .last_i        (last),
    .gap_expired_i (gap_expired),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .gap_load_o    (gap_load),
    .req_o         (req_o),
    .cmd_o         (cmd_o),
    .data_o        (data_o),
    .busy_o        (busy_o),
    .ready_o       (ready_o),
    .timeout_o     (timeout_o)
  );

  ap_probe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .max_i  (max_probes_i),
    .cnt_o  (probe_cnt_o),
    .last_o (last)
  );

  ap_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .gap_i     (gap_i),
    .expired_o (gap_expired)
  );
endmodule

// File: tb/ack_poll_seq_bench.sv
module ack_poll_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic [7:0] max_probes_i = 8'd1;
  logic [7:0] gap_i = '0;
  logic       hold_bus_i = 1'b0;
  logic       req_o;
  logic [1:0] cmd_o;
  logic [7:0] data_o;
  logic       done_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       busy_o, ready_o, timeout_o;
  logic [7:0] probe_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk_i = ~clk_i;

  ack_poll_seq u_ack_poll_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .max_probes_i(max_probes_i), .gap_i(gap_i), .hold_bus_i(hold_bus_i),
    .req_o(req_o), .cmd_o(cmd_o), .data_o(data_o), .done_i(done_i), .ack_i(ack_i),
    .busy_o(busy_o), .ready_o(ready_o), .timeout_o(timeout_o), .probe_cnt_o(probe_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_max(input int m);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic int exp_probes(input int nacks, input int m);
    return (nacks < eff_max(m)) ? nacks + 1 : eff_max(m);
  endfunction

  // byte-engine model: wait for a request, check it, hold it lat cycles, complete it
  task automatic serve(input logic [1:0] ecmd, input bit ack, input int lat,
                       input int exp_gap, input bit poke, input string tag);
    int gap = 0;
    logic [1:0] c0;
    logic [7:0] d0;
    while (!req_o && gap < 300) begin gap++; @(negedge clk_i); end
    check(gap == exp_gap, {tag, " request gap"}, gap, exp_gap);
    check(cmd_o == ecmd, {tag, " command"}, cmd_o, ecmd);
    if (ecmd == 2'd1)
      check(data_o == {dev_addr_i, 1'b0}, "R2 probe byte", data_o, {dev_addr_i, 1'b0});
    c0 = cmd_o; d0 = data_o;
    for (int i = 0; i < lat; i++) begin
      if (i == 0 && poke) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(req_o && cmd_o == c0 && data_o == d0, "R10 request held",
            {req_o, cmd_o, data_o}, {1'b1, c0, d0});
    end
    done_i = 1'b1; ack_i = ack;
    @(negedge clk_i);
    done_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic scenario(input int nacks, input int m, input int gap, input bit hold,
                          input logic [6:0] dev);
    int np;
    bit to;
    np = exp_probes(nacks, m);
    to = (nacks >= eff_max(m));
    dev_addr_i = dev; max_probes_i = m[7:0]; gap_i = gap[7:0]; hold_bus_i = hold;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!ready_o && !timeout_o && probe_cnt_o == 0, "R9 start clears flags",
          {ready_o, timeout_o, probe_cnt_o}, 0);
    check(req_o && busy_o, "R9 request next cycle", req_o, 1);
    for (int p = 0; p < np; p++) begin
      bit ack;
      ack = (p == nacks);
      serve(2'd0, 1'b0, 1 + $urandom_range(2), (p == 0) ? 0 : gap + 1,
            1'b0, (p == 0) ? "R9 first start" : "R3 start after gap");
      serve(2'd1, ack, 1 + $urandom_range(2), 0, (p == 1), "R2 probe byte");
      if (!ack)
        serve(2'd2, 1'b0, 1 + $urandom_range(2), 0, 1'b0,
              (p == np - 1) ? "R7 stop on timeout" : "R3 stop after nack");
      else if (!hold)
        serve(2'd2, 1'b0, 1 + $urandom_range(2), 0, 1'b0, "R4 stop after ack");
    end
    if (to) begin
      check(timeout_o && !ready_o && !busy_o, "R7 timeout flags",
            {timeout_o, ready_o, busy_o}, 3'b100);
    end else if (hold) begin
      check(ready_o && !busy_o && !req_o, "R5 ready without stop",
            {ready_o, busy_o, req_o}, 3'b100);
    end else begin
      check(ready_o && !busy_o && !timeout_o, "R4 ready after stop",
            {ready_o, busy_o, timeout_o}, 3'b100);
    end
    check(probe_cnt_o == np, "R6/R8 probe count", probe_cnt_o, np);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(!req_o, "R7 no further commands", req_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    check(!busy_o && !ready_o && !timeout_o && !req_o && probe_cnt_o == 0,
          "R1 reset state", {busy_o, ready_o, timeout_o, req_o, probe_cnt_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !req_o && probe_cnt_o == 0, "R1 after release",
          {busy_o, req_o, probe_cnt_o}, 0);
    // directed corners
    scenario(0, 1, 0, 1'b0, 7'h50);   // immediate ack, stop
    scenario(2, 3, 0, 1'b0, 7'h2a);   // ack on the last allowed probe
    scenario(3, 3, 4, 1'b0, 7'h51);   // timeout exactly at limit
    scenario(1, 0, 2, 1'b1, 7'h7f);   // limit 0 acts as 1
    scenario(4, 9, 7, 1'b1, 7'h01);   // hold bus, long gap, R8 poke
    scenario(5, 255, 1, 1'b0, 7'h00);
    for (int n = 0; n < 40; n++)
      scenario($urandom_range(6), $urandom_range(7), $urandom_range(6),
               $urandom_range(1), 7'($urandom));
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule